// File: doc/BRIEF.md
# Cache Block Refill Controller with Selectable Memory Organization

This controller fills one four-word cache block from a slow backing store and reproduces exactly the refill latency that a chosen memory organization would cost. A parameter picks the organization. The first option is a store that returns one word per access. The second is a store as wide as the whole block. The third is four one-word banks that start their accesses together and then hand their words over one per cycle. The backing store is held inside the block as four banks of computed contents. Word `w` of block `b` lives in bank `w`, so the two low bits of the word address select the bank.

The cache side raises a one-cycle request together with a block number. The controller then counts the cycles the chosen organization would spend: one to send the address, fifteen for each access it must start, and one for each transfer it must make. It delivers each word in its own lane of a block-wide data bus, marked by a per-word valid strobe. The done pulse accompanies the last word. Only one refill is in flight at a time. A new request is taken in the cycle that shows done, or in any later cycle.

Top module: `blk_refill_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the valid strobes, the done pulse and every data lane are zero.
- R2: With the one-word-wide organization (ORG=0), the strobe of word i is high in the single cycle that follows the clock edge 1+16·(i+1) edges after the accepting edge. Done therefore comes 65 edges after acceptance.
- R3: With the block-wide organization (ORG=1), all four strobes and done are high together in the single cycle that follows the edge 17 edges after acceptance.
- R4: With the interleaved organization (ORG=2), the strobe of word i is high in the single cycle that follows the edge 17+i edges after acceptance. Done comes 20 edges after acceptance.
- R5: Lane i (bits 32·i+31 down to 32·i) of the data bus carries the word at word address 4·b+i, where b is the requested block. The storage word at word address a is (a·32'h01000193) XOR 32'hA5A5_5A5A, computed modulo 2^32.
- R6: Each refill pulses every strobe bit exactly once, in ascending word order. Done is high for exactly one cycle, and that cycle is the cycle of the last word.
- R7: A request that arrives while a refill is in flight is ignored. The running refill finishes with its own block, and no second done follows.
- R8: A request presented in the cycle that shows done is accepted and starts a full refill.
- R9: A reset in the middle of a refill clears the outputs and abandons the refill, so no strobe or done follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Refill request, sampled on the rising edge |
| req_blk | input | BLK_AW | Block number of the request |
| wd_data | output | 4·32 | Block-wide data, one lane per word |
| wd_valid | output | 4 | Per-word valid strobe |
| done | output | 1 | One-cycle pulse with the last word |

## Verification
The same table of block numbers is driven into three instances, one per organization. The lowest and highest block numbers are included, and so are middle values whose bit patterns alternate. The arrival edge of each word separates the three schedules from one another: sequential accesses, a single wide access, and overlapped bank accesses. The lane contents show whether each word came from the right bank and the right row, so a swapped lane or a misrouted block index is exposed. Directed runs then inject a request in the middle of a refill, inject a request in the done cycle, and apply a reset in the middle of a refill. These runs separate correct acceptance rules from a controller that restarts, drops requests or carries on after a reset.

// File: rtl/refill_pkg.sv
// Package: constants and helpers shared by the refill controller.
// Assumes a four-word block of 32-bit words.
package refill_pkg;
    localparam int WORD_W = 32;
    localparam int NUM_WORDS = 4;

    localparam int ORG_NARROW = 0;
    localparam int ORG_WIDE = 1;
    localparam int ORG_INTERLEAVED = 2;

    // Returns the edge count, after acceptance, at which word idx is transferred.
    function automatic int xfer_cycle(int org, int idx, int adr, int acc, int xfr);
        if (org == ORG_NARROW)
            return adr + (idx + 1) * (acc + xfr);
        else if (org == ORG_WIDE)
            return adr + acc + xfr;
        else
            return adr + acc + (idx + 1) * xfr;
    endfunction

    // Returns the fixed storage contents at a word address.
    function automatic logic [WORD_W-1:0] seed_word(logic [31:0] wa);
        return (wa * 32'h0100_0193) ^ 32'hA5A5_5A5A;
    endfunction
endpackage

// File: rtl/refill_bank.sv
// Module: one storage bank with computed read-only contents.
// Row e of bank k holds the word at word address e*NUM_WORDS+k.
// The read is combinational; the access time is counted by the scheduler.
module refill_bank
    import refill_pkg::*;
#(
    parameter int BANK_IDX = 0,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic [AW-1:0]     row,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] cells [DEPTH];

    // Fill every row with its computed word.
    for (genvar e = 0; e < DEPTH; e++) begin : g_row
        assign cells[e] = seed_word(32'(e * NUM_WORDS + BANK_IDX));
    end

    // Read the addressed row.
    assign rdata = cells[row];
endmodule

// File: rtl/refill_sched.sv
// Module: refill timing scheduler.
// It counts edges from acceptance and flags the edge at which each word is
// transferred, according to the organization chosen by ORG.
// It assumes that req is a level sampled on the rising edge; a request that
// arrives while busy is dropped.
module refill_sched
    import refill_pkg::*;
#(
    parameter int ORG = ORG_INTERLEAVED,
    parameter int ADR_CYC = 1,
    parameter int ACC_CYC = 15,
    parameter int XFR_CYC = 1,
    localparam int TOTAL = xfer_cycle(ORG, NUM_WORDS - 1, ADR_CYC, ACC_CYC, XFR_CYC),
    localparam int CW = $clog2(TOTAL + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    output logic                 accept,
    output logic [NUM_WORDS-1:0] xfer,
    output logic                 last
);
    logic          busy;
    logic [CW-1:0] cnt;

    assign accept = req && !busy;
    assign last   = busy && (cnt == CW'(TOTAL));

    // Track the refill in flight and count its edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            cnt  <= CW'(1);
        end else if (last) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Decode the transfer edge of each word.
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_xfer
        localparam int TI = xfer_cycle(ORG, i, ADR_CYC, ACC_CYC, XFR_CYC);
        assign xfer[i] = busy && (cnt == CW'(TI));
    end

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req && !last) |=> (busy && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/blk_refill_ctrl.sv
// Module: cache block refill controller (top).
// It latches the block number on acceptance, reads the four banks, and
// registers each word into its lane on that word's transfer edge.
// Done is raised with the last word.
module blk_refill_ctrl
    import refill_pkg::*;
#(
    parameter int ORG = ORG_INTERLEAVED,
    parameter int BLK_AW = 4,
    parameter int ADR_CYC = 1,
    parameter int ACC_CYC = 15,
    parameter int XFR_CYC = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic [BLK_AW-1:0]           req_blk,
    output logic [NUM_WORDS*WORD_W-1:0] wd_data,
    output logic [NUM_WORDS-1:0]        wd_valid,
    output logic                        done
);
    localparam int DEPTH = 2 ** BLK_AW;

    logic                 accept;
    logic                 last;
    logic [NUM_WORDS-1:0] xfer;
    logic [BLK_AW-1:0]    blk_q;
    logic [WORD_W-1:0]    bank_rd [NUM_WORDS];
    logic [NUM_WORDS-1:0] seen;

    refill_sched #(
        .ORG(ORG), .ADR_CYC(ADR_CYC), .ACC_CYC(ACC_CYC), .XFR_CYC(XFR_CYC)
    ) u_sched (
        .clk(clk), .rst_n(rst_n), .req(req),
        .accept(accept), .xfer(xfer), .last(last)
    );

    // Hold the block number of the refill in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blk_q <= '0;
        else if (accept)
            blk_q <= req_blk;
    end

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_bank
        refill_bank #(.BANK_IDX(k), .DEPTH(DEPTH)) u_bank (
            .row(blk_q), .rdata(bank_rd[k])
        );

        // Load lane k on its transfer edge; hold it otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)
                wd_data[k*WORD_W +: WORD_W] <= '0;
            else if (xfer[k])
                wd_data[k*WORD_W +: WORD_W] <= bank_rd[k];
        end
    end

    // Register the strobes and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_valid <= '0;
            done     <= 1'b0;
        end else begin
            wd_valid <= xfer;
            done     <= last;
        end
    end

    // Record the words already delivered in this refill (checking only).
    always_ff @(posedge clk) begin
        if (!rst_n || accept)
            seen <= '0;
        else
            seen <= seen | wd_valid;
    end

    // R6
    done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> wd_valid[NUM_WORDS-1]);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    for (genvar i = 1; i < NUM_WORDS; i++) begin : g_ord
        word_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wd_valid[i] |-> &(seen[i-1:0] | wd_valid[i-1:0]));
    end

    // R6
    strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wd_valid & seen) == '0));
endmodule

// File: tb/blk_refill_ctrl_tb.sv
module blk_refill_ctrl_tb;
    import refill_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] req_s = '0;
    logic [3:0] blk_s = '0;

    logic [127:0] data_o [3];
    logic [3:0]   val_o  [3];
    logic         done_o [3];

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    blk_refill_ctrl #(.ORG(ORG_NARROW)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n), .req(req_s[0]), .req_blk(blk_s),
        .wd_data(data_o[0]), .wd_valid(val_o[0]), .done(done_o[0]));
    blk_refill_ctrl #(.ORG(ORG_WIDE)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .req(req_s[1]), .req_blk(blk_s),
        .wd_data(data_o[1]), .wd_valid(val_o[1]), .done(done_o[1]));
    blk_refill_ctrl #(.ORG(ORG_INTERLEAVED)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req_s[2]), .req_blk(blk_s),
        .wd_data(data_o[2]), .wd_valid(val_o[2]), .done(done_o[2]));

    localparam logic [3:0] VEC [6] = '{4'd0, 4'd15, 4'd5, 4'd10, 4'd1, 4'd14};

    int          t_first [3][4];
    logic [31:0] d_first [3][4];
    logic [31:0] d_last  [3][4];
    int          dn_first [3];
    int          dn_last  [3];
    int          dn_cnt   [3];

    function automatic int exp_t(int org, int i);
        if (org == 0) return 1 + 16 * (i + 1);
        if (org == 1) return 17;
        return 17 + i;
    endfunction

    function automatic logic [31:0] exp_w(int blk, int i);
        logic [31:0] a;
        a = 32'(blk * 4 + i);
        return (a * 32'h0100_0193) ^ 32'hA5A5_5A5A;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Start a refill on the DUTs in mask; sample win cycles; optional injection.
    task automatic run(logic [3:0] blk, logic [2:0] mask, int win, int inj_n, logic [3:0] inj_blk);
        for (int d = 0; d < 3; d++) begin
            dn_first[d] = 0; dn_last[d] = 0; dn_cnt[d] = 0;
            for (int i = 0; i < 4; i++) begin
                t_first[d][i] = 0; d_first[d][i] = '0; d_last[d][i] = '0;
            end
        end
        @(negedge clk);
        blk_s = blk; req_s = mask;
        @(posedge clk);
        @(negedge clk);
        req_s = '0;
        for (int n = 1; n <= win; n++) begin
            @(posedge clk);
            @(negedge clk);
            for (int d = 0; d < 3; d++) begin
                for (int i = 0; i < 4; i++) begin
                    if (val_o[d][i]) begin
                        if (t_first[d][i] == 0) begin
                            t_first[d][i] = n;
                            d_first[d][i] = data_o[d][i*32 +: 32];
                        end
                        d_last[d][i] = data_o[d][i*32 +: 32];
                    end
                end
                if (done_o[d]) begin
                    if (dn_cnt[d] == 0) dn_first[d] = n;
                    dn_last[d] = n;
                    dn_cnt[d]++;
                end
            end
            if (n == inj_n) begin
                blk_s = inj_blk; req_s = mask;
            end else begin
                req_s = '0;
            end
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        for (int d = 0; d < 3; d++) begin
            chk(val_o[d] == 4'b0, "R1 valid", val_o[d], 0);
            chk(done_o[d] == 1'b0, "R1 done", done_o[d], 0);
            chk(data_o[d] == '0, "R1 data", data_o[d][63:0], 0);
        end
        rst_n = 1'b1;

        // Table walk: every organization, several block numbers (R2 R3 R4 R5 R6)
        for (int v = 0; v < 6; v++) begin
            run(VEC[v], 3'b111, 70, 0, 4'd0);
            for (int d = 0; d < 3; d++) begin
                for (int i = 0; i < 4; i++) begin
                    chk(t_first[d][i] == exp_t(d, i),
                        d == 0 ? "R2 word time" : (d == 1 ? "R3 word time" : "R4 word time"),
                        t_first[d][i], exp_t(d, i));
                    chk(d_first[d][i] == exp_w(VEC[v], i), "R5 lane data",
                        d_first[d][i], exp_w(VEC[v], i));
                end
                chk(dn_first[d] == exp_t(d, 3), "R6 done time", dn_first[d], exp_t(d, 3));
                chk(dn_cnt[d] == 1, "R6 done count", dn_cnt[d], 1);
            end
        end

        // R7: request during a narrow refill is ignored
        run(4'd3, 3'b001, 140, 5, 4'd9);
        chk(dn_cnt[0] == 1, "R7 done count", dn_cnt[0], 1);
        chk(dn_first[0] == 65, "R7 done time", dn_first[0], 65);
        for (int i = 0; i < 4; i++)
            chk(d_last[0][i] == exp_w(3, i), "R7 lane data", d_last[0][i], exp_w(3, i));

        // R8: request in the done cycle is accepted (interleaved)
        run(4'd2, 3'b100, 60, 20, 4'd7);
        chk(dn_cnt[2] == 2, "R8 done count", dn_cnt[2], 2);
        chk(dn_last[2] == 41, "R8 second done time", dn_last[2], 41);
        for (int i = 0; i < 4; i++)
            chk(d_last[2][i] == exp_w(7, i), "R8 lane data", d_last[2][i], exp_w(7, i));

        // R9: reset in the middle of a refill abandons it
        @(negedge clk);
        blk_s = 4'd6; req_s = 3'b111;
        @(negedge clk);
        req_s = '0;
        repeat (16) @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int d = 0; d < 3; d++) begin
            chk(val_o[d] == 4'b0 && done_o[d] == 1'b0, "R9 cleared", {val_o[d], done_o[d]}, 0);
            chk(data_o[d] == '0, "R9 data cleared", data_o[d][63:0], 0);
        end
        rst_n = 1'b1;
        begin
            int seen_any;
            seen_any = 0;
            for (int n = 0; n < 80; n++) begin
                @(negedge clk);
                for (int d = 0; d < 3; d++)
                    if (val_o[d] != 4'b0 || done_o[d]) seen_any++;
            end
            chk(seen_any == 0, "R9 no output after reset", seen_any, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule